// File: doc/BRIEF.md
# Interrupt Source Mapping Controller

This block sits between interrupt-producing devices and the interrupt-vector inputs of a processor. It takes 32 level-sensitive lines from PCI-side devices and 16 lines from on-board devices, and drives a flat set of 48 vector outputs. Vectors 0 to 31 follow the PCI lines and vectors 32 to 47 follow the on-board lines. Each PCI mapping register controls four adjacent PCI lines. Each on-board mapping register controls one on-board line. Bit 31 of a mapping register is its enable. While that bit is clear, every vector the register controls is held low.

A 16-line legacy ISA interrupt input also feeds the on-board vectors, through a fixed translation table. Only five ISA lines have a destination vector; the others are dropped. Software reaches the mapping registers through a simple register port that uses valid, write, address and data signals, with a 64 KB offset space. Each register takes the upper 32-bit word of an 8-byte slot. Writes may change only the enable bit; all other bits keep their value.

Top module: `irq_map_ctrl`

## Requirements
- R1: After reset, reading offset 0x0C04 + 8*i returns (0x1F << 6) | (i << 2) for PCI register i = 0..7, and reading offset 0x1004 + 8*k returns 0 for on-board register k = 0..15. Every vector output is low after reset.
- R2: PCI mapping register i is at offset 0x0C00 + 8*i + 4. The index is formed as (offset & 0x3F) >> 3 for offsets 0x0C00..0x0C3F.
- R3: On-board mapping register k is at offset 0x1000 + 8*k + 4 for k = 0..15. The index is formed as (offset & 0xFF) >> 3.
- R4: An access with offset bit 2 clear does not address a register. A write of this kind changes no register and no output. A read of this kind returns 0.
- R5: A write replaces only bit 31, the enable bit. Bits 30:0 keep their previous value. After a write of 0xFFFFFFFF, PCI register i reads 0x80000000 | ((0x1F << 6) | (i << 2)) and on-board register k reads 0x80000000.
- R6: For n = 0..31, vector output n equals PCI line n AND the enable of PCI register n >> 2.
- R7: For k = 0..15, vector output 32 + k equals the combined level of on-board line k AND the enable of on-board register k. The combined level is the on-board line OR any ISA line that translates to vector 32 + k.
- R8: ISA lines translate as follows: 1 to vector 0x29, 4 to 0x2B, 6 to 0x27, 7 to 0x22 and 12 to 0x2A. Every other ISA line drives no vector.
- R9: A vector output follows its input line in the same cycle. A change to an enable bit reaches the outputs in the cycle after the clock edge that accepts the write.
- R10: A read of any offset outside both register windows returns 0, and so does a read at 0x1080 or higher. A write to any such offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access valid this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Byte offset inside the configuration window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 unless a register read hits |
| pci_irq | input | 32 | PCI-side interrupt levels |
| ob_irq | input | 16 | On-board interrupt levels |
| isa_irq | input | 16 | Legacy ISA interrupt levels |
| ivec | output | 48 | Gated interrupt-vector levels |

## Verification
A corrupted enable bit shows up at once as a group of four PCI vectors, or a single on-board vector, that is stuck low or passes its input when it should not. A wrong index in the decode shows the wrong register value on the very read that follows, and later moves the enable to the wrong vectors. A write mask that leaks changes the low bits of a register on the read after any write of all ones. A translation-table error shows as the wrong vector rising, or no vector rising, in the same cycle the ISA line rises. For these reasons the bench sweeps single-hot inputs over every line under several enable patterns.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

    localparam int REG_W      = 32;
    localparam int ENABLE_BIT = 31;

    // Legacy line to vector translation: bit 6 = has a vector, bits 5:0 = vector.
    function automatic logic [6:0] isa_route(input int line);
        case (line)
            1:       return {1'b1, 6'h29};
            4:       return {1'b1, 6'h2B};
            6:       return {1'b1, 6'h27};
            7:       return {1'b1, 6'h22};
            12:      return {1'b1, 6'h2A};
            default: return 7'd0;
        endcase
    endfunction

endpackage

// File: rtl/irqmap_regs.sv
module irqmap_regs
    import irqmap_pkg::*;
#(
    parameter int                NP        = 8,
    parameter int                NO        = 16,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PCI_BASE  = 16'h0C00,
    parameter logic [ADDR_W-1:0] OB_BASE   = 16'h1000,
    parameter logic [REG_W-1:0]  PROT_MASK = 32'h7FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NP-1:0]     pci_en,
    output logic [NO-1:0]     ob_en
);

    localparam int PIDX_W = (NP > 1) ? $clog2(NP) : 1;
    localparam int OIDX_W = (NO > 1) ? $clog2(NO) : 1;
    localparam logic [ADDR_W-1:0] PCI_SPAN = ADDR_W'(NP * 8);
    localparam logic [ADDR_W-1:0] OB_SPAN  = ADDR_W'(NO * 8);

    typedef struct packed {
        logic [NP-1:0][REG_W-1:0] pci;
        logic [NO-1:0][REG_W-1:0] ob;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NP; i++) begin
            s.pci[i] = (REG_W'(32'h1F) << 6) | (REG_W'(i) << 2);
        end
        return s;
    endfunction

    localparam state_t RST_STATE = reset_state();

    state_t state_d, state_q;

    logic [ADDR_W-1:0] pci_off, ob_off;
    logic              pci_hit, ob_hit, word_sel;
    logic [PIDX_W-1:0] pidx;
    logic [OIDX_W-1:0] oidx;

    always_comb begin
        pci_off  = reg_addr - PCI_BASE;
        ob_off   = reg_addr - OB_BASE;
        pci_hit  = (pci_off < PCI_SPAN);
        ob_hit   = (ob_off < OB_SPAN);
        word_sel = reg_addr[2];
        pidx     = pci_off[3 +: PIDX_W];
        oidx     = ob_off[3 +: OIDX_W];
    end

    // Next-state computation
    always_comb begin
        state_d = state_q;
        if (reg_valid && reg_write && word_sel) begin
            if (pci_hit) begin
                state_d.pci[pidx] = (state_q.pci[pidx] & PROT_MASK) | (reg_wdata & ~PROT_MASK);
            end else if (ob_hit) begin
                state_d.ob[oidx] = (state_q.ob[oidx] & PROT_MASK) | (reg_wdata & ~PROT_MASK);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_valid && !reg_write && word_sel) begin
            if (pci_hit) begin
                reg_rdata = state_q.pci[pidx];
            end else if (ob_hit) begin
                reg_rdata = state_q.ob[oidx];
            end
        end
    end

    generate
        for (genvar i = 0; i < NP; i++) begin : g_pen
            assign pci_en[i] = state_q.pci[i][ENABLE_BIT];
        end
        for (genvar k = 0; k < NO; k++) begin : g_oen
            assign ob_en[k] = state_q.ob[k][ENABLE_BIT];
        end
    endgenerate

endmodule

// File: rtl/irqmap_isa_xlat.sv
module irqmap_isa_xlat
    import irqmap_pkg::*;
#(
    parameter int ISA_N    = 16,
    parameter int NO       = 16,
    parameter int OB_FIRST = 32
) (
    input  logic [ISA_N-1:0] isa_irq,
    output logic [NO-1:0]    ob_from_isa
);

    always_comb begin
        ob_from_isa = '0;
        for (int k = 0; k < NO; k++) begin
            for (int l = 0; l < ISA_N; l++) begin
                if (isa_route(l) == {1'b1, 6'(OB_FIRST + k)}) begin
                    ob_from_isa[k] = ob_from_isa[k] | isa_irq[l];
                end
            end
        end
    end

endmodule

// File: rtl/irqmap_gate.sv
module irqmap_gate #(
    parameter int NP  = 8,
    parameter int LPR = 4,
    parameter int NO  = 16
) (
    input  logic [NP*LPR-1:0]    pci_lvl,
    input  logic [NO-1:0]        ob_lvl,
    input  logic [NP-1:0]        pci_en,
    input  logic [NO-1:0]        ob_en,
    output logic [NP*LPR+NO-1:0] ivec
);

    localparam int NPL = NP * LPR;

    generate
        for (genvar n = 0; n < NPL; n++) begin : g_pci
            assign ivec[n] = pci_lvl[n] & pci_en[n / LPR];
        end
        for (genvar k = 0; k < NO; k++) begin : g_ob
            assign ivec[NPL + k] = ob_lvl[k] & ob_en[k];
        end
    endgenerate

endmodule

// File: rtl/irq_map_ctrl.sv
module irq_map_ctrl
    import irqmap_pkg::*;
#(
    parameter int                NP        = 8,
    parameter int                LPR       = 4,
    parameter int                NO        = 16,
    parameter int                ISA_N     = 16,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PCI_BASE  = 16'h0C00,
    parameter logic [ADDR_W-1:0] OB_BASE   = 16'h1000,
    parameter logic [REG_W-1:0]  PROT_MASK = 32'h7FFF_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [NP*LPR-1:0]    pci_irq,
    input  logic [NO-1:0]        ob_irq,
    input  logic [ISA_N-1:0]     isa_irq,
    output logic [NP*LPR+NO-1:0] ivec
);

    localparam int NPL = NP * LPR;

    logic [NP-1:0] pci_en;
    logic [NO-1:0] ob_en;
    logic [NO-1:0] ob_from_isa;
    logic [NO-1:0] ob_lvl;

    irqmap_regs #(
        .NP(NP), .NO(NO), .ADDR_W(ADDR_W),
        .PCI_BASE(PCI_BASE), .OB_BASE(OB_BASE), .PROT_MASK(PROT_MASK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pci_en(pci_en), .ob_en(ob_en)
    );

    irqmap_isa_xlat #(
        .ISA_N(ISA_N), .NO(NO), .OB_FIRST(NPL)
    ) u_xlat (
        .isa_irq(isa_irq), .ob_from_isa(ob_from_isa)
    );

    assign ob_lvl = ob_irq | ob_from_isa;

    irqmap_gate #(
        .NP(NP), .LPR(LPR), .NO(NO)
    ) u_gate (
        .pci_lvl(pci_irq), .ob_lvl(ob_lvl),
        .pci_en(pci_en), .ob_en(ob_en), .ivec(ivec)
    );

endmodule

// File: rtl/irqmap_checker.sv
module irqmap_checker #(
    parameter int                NP       = 8,
    parameter int                LPR      = 4,
    parameter int                NO       = 16,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] PCI_BASE = 16'h0C00
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_valid,
    input logic                 reg_write,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [31:0]          reg_rdata,
    input logic [NP*LPR-1:0]    pci_irq,
    input logic [NP*LPR+NO-1:0] ivec,
    input logic [NP-1:0]        pci_en,
    input logic [NO-1:0]        ob_en
);

    localparam int NPL = NP * LPR;

    // R4: a write to the lower word leaves every enable untouched
    p_lowword_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && !reg_addr[2]) |=> ($stable(pci_en) && $stable(ob_en)));

    // R4: a read of the lower word yields zero
    p_lowword_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && !reg_addr[2]) |-> (reg_rdata == '0));

    // R6: a PCI vector never rises without its input line
    p_pci_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ivec[NPL-1:0] & ~pci_irq) == '0));

    // R7: a disabled on-board vector stays low
    p_ob_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ivec[NPL+NO-1:NPL] & ~ob_en) == '0));

    // R10: writes below the PCI window change no enable
    p_undecoded_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && (reg_addr < PCI_BASE)) |=> ($stable(pci_en) && $stable(ob_en)));

    // R10: reads below the PCI window yield zero
    p_undecoded_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && (reg_addr < PCI_BASE)) |-> (reg_rdata == '0));

endmodule

bind irq_map_ctrl irqmap_checker #(
    .NP(NP), .LPR(LPR), .NO(NO), .ADDR_W(ADDR_W), .PCI_BASE(PCI_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .pci_irq(pci_irq), .ivec(ivec),
    .pci_en(pci_en), .ob_en(ob_en)
);

// File: tb/irq_map_ctrl_bench.sv
`timescale 1ns/1ps
module irq_map_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pci_irq = '0;
    logic [15:0] ob_irq = '0;
    logic [15:0] isa_irq = '0;
    logic [47:0] ivec;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    logic [7:0]  pen = '0;
    logic [15:0] oen = '0;

    always #5 clk = ~clk;

    irq_map_ctrl u_irq_map_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pci_irq(pci_irq), .ob_irq(ob_irq), .isa_irq(isa_irq), .ivec(ivec)
    );

    function automatic logic [31:0] pci_rst(input int i);
        return (32'h1F << 6) | (32'(i) << 2);
    endfunction

    function automatic logic [47:0] exp_ivec(input logic [31:0] p, input logic [15:0] o,
                                             input logic [15:0] s);
        logic [47:0] r;
        logic [15:0] lvl;
        lvl = o;
        lvl[9]  = lvl[9]  | s[1];   // 0x29 - 32
        lvl[11] = lvl[11] | s[4];   // 0x2B - 32
        lvl[7]  = lvl[7]  | s[6];   // 0x27 - 32
        lvl[2]  = lvl[2]  | s[7];   // 0x22 - 32
        lvl[10] = lvl[10] | s[12];  // 0x2A - 32
        for (int n = 0; n < 32; n++) r[n] = p[n] & pen[n / 4];
        for (int k = 0; k < 16; k++) r[32 + k] = lvl[k] & oen[k];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic set_enables(input logic [7:0] p, input logic [15:0] o);
        for (int i = 0; i < 8; i++) wr(16'h0C04 + 16'(8 * i), {p[i], 31'h7FFF_FFFF});
        for (int k = 0; k < 16; k++) wr(16'h1004 + 16'(8 * k), {o[k], 31'h0});
        pen = p; oen = o;
    endtask

    task automatic drive_check(input string req, input logic [31:0] p, input logic [15:0] o,
                               input logic [15:0] s);
        @(negedge clk);
        pci_irq = p; ob_irq = o; isa_irq = s;
        #1 check(req, 64'(ivec), 64'(exp_ivec(p, o, s)));
    endtask

    task automatic sweep(input string tag);
        for (int n = 0; n < 32; n++) drive_check({"R6 ", tag}, 32'd1 << n, '0, '0);
        for (int k = 0; k < 16; k++) drive_check({"R7 ", tag}, '0, 16'd1 << k, '0);
        for (int l = 0; l < 16; l++) drive_check({"R8 ", tag}, '0, '0, 16'd1 << l);
        drive_check({"R6 R7 R8 all ", tag}, '1, '1, '1);
        drive_check({"R7 R8 mix ", tag}, 32'hA5A5_5A5A, 16'h0F0F, 16'h10D2);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        #1 check("R1 vectors low in reset", 64'(ivec), 64'd0);
        rst_n = 1'b1;

        // R1 / R2 / R3: reset values at every register slot
        for (int i = 0; i < 8; i++) begin
            rd(16'h0C04 + 16'(8 * i), d);
            check("R1 R2 pci reset", 64'(d), 64'(pci_rst(i)));
        end
        for (int k = 0; k < 16; k++) begin
            rd(16'h1004 + 16'(8 * k), d);
            check("R1 R3 ob reset", 64'(d), 64'd0);
        end

        // R4: lower words read zero; writes there are dropped
        rd(16'h0C00, d); check("R4 pci low read", 64'(d), 64'd0);
        rd(16'h1008, d); check("R4 ob low read", 64'(d), 64'd0);
        wr(16'h0C08, 32'hFFFF_FFFF);
        wr(16'h1010, 32'hFFFF_FFFF);
        rd(16'h0C0C, d); check("R4 pci low write ignored", 64'(d), 64'(pci_rst(1)));
        rd(16'h1014, d); check("R4 ob low write ignored", 64'(d), 64'd0);
        drive_check("R4 outputs unchanged", '1, '1, '0);

        // R10: undecoded offsets
        rd(16'h1084, d); check("R10 read 0x1084", 64'(d), 64'd0);
        rd(16'h0C44, d); check("R10 read 0x0C44", 64'(d), 64'd0);
        rd(16'h0004, d); check("R10 read 0x0004", 64'(d), 64'd0);
        wr(16'h1084, 32'hFFFF_FFFF);
        wr(16'h0C44, 32'hFFFF_FFFF);
        wr(16'h0004, 32'hFFFF_FFFF);
        drive_check("R10 writes ignored", '1, '1, '1);

        // R5: write mask
        for (int i = 0; i < 8; i++) begin
            wr(16'h0C04 + 16'(8 * i), 32'hFFFF_FFFF);
            rd(16'h0C04 + 16'(8 * i), d);
            check("R5 pci mask set", 64'(d), 64'(32'h8000_0000 | pci_rst(i)));
            wr(16'h0C04 + 16'(8 * i), 32'h0000_0000);
            rd(16'h0C04 + 16'(8 * i), d);
            check("R5 pci mask clear", 64'(d), 64'(pci_rst(i)));
        end
        for (int k = 0; k < 16; k++) begin
            wr(16'h1004 + 16'(8 * k), 32'hFFFF_FFFF);
            rd(16'h1004 + 16'(8 * k), d);
            check("R5 ob mask set", 64'(d), 64'h8000_0000);
            wr(16'h1004 + 16'(8 * k), 32'h7FFF_FFFF);
            rd(16'h1004 + 16'(8 * k), d);
            check("R5 ob mask clear", 64'(d), 64'd0);
        end

        // R9: input follows same cycle; enable takes effect after the write edge
        @(negedge clk);
        pci_irq = 32'h0000_0010; ob_irq = '0; isa_irq = '0;
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 16'h0C0C; reg_wdata = 32'h8000_0000;
        #1 check("R9 before write edge", 64'(ivec[4]), 64'd0);
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
        #1 check("R9 after write edge", 64'(ivec[4]), 64'd1);
        pci_irq = 32'h0000_0000;
        #1 check("R9 input drop same cycle", 64'(ivec[4]), 64'd0);
        wr(16'h0C0C, 32'h0);

        // Sweeps over several enable patterns
        set_enables(8'h00, 16'h0000); sweep("all off");
        set_enables(8'hFF, 16'hFFFF); sweep("all on");
        set_enables(8'hA5, 16'h5A3C); sweep("pattern a");
        set_enables(8'h3C, 16'h8E61); sweep("pattern b");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule